// File: doc/BRIEF.md
# Banked Memory-Map Write Router

This block sits between the write port of a small 8-bit processor and the storage and peripheral targets of its 64 KiB address space. For every write it picks out the one target that the 16-bit address selects and raises that target's strobe. Along with the strobe it gives a target-local address and a registered copy of the data byte. Nothing is strobed for holes in the map.

There are eleven targets. The low half of the map goes to the bank controller. The upper half holds video memory, a banked external memory, work memory together with its mirror, and a sprite attribute table that fills only part of its page. The top page splits into peripheral registers, scratch memory and the interrupt-enable byte. The external memory bank offset arrives as an input and is added to the in-window offset. The router holds no bank state and has no read path.

Strobes, local address and data are registered, so they appear one clock after the write is presented. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `bus_write_router`

## Requirements
- R1: A write to 0x0000–0x7FFF raises strobe bit 0 (bank controller) with local address wr_addr[14:0].
- R2: A write to 0x8000–0x9FFF raises strobe bit 1 (video memory) with local address wr_addr[12:0].
- R3: A write to 0xA000–0xBFFF raises strobe bit 2 (external memory) with local address (xram_base + wr_addr[12:0]) modulo 2^LOC_W.
- R4: A write to 0xC000–0xFDFF raises strobe bit 3 (work memory) with local address wr_addr[12:0]. This covers the mirror window 0xE000–0xFDFF.
- R5: A write to 0xFE00–0xFE9F raises strobe bit 4 (sprite table) with local address wr_addr[7:0]. A write to 0xFEA0–0xFEFF raises no strobe.
- R6: A write to 0xFF80–0xFFFE raises strobe bit 5 (scratch memory) with local address wr_addr[6:0]. A write to 0xFFFF raises strobe bit 6 (interrupt enable) with local address 0.
- R7: Peripheral page 0xFF00–0xFF7F:
  - 0xFF0F raises bit 7 (interrupt flags) with local address 0.
  - 0xFF00 raises bit 8 (keypad) with local address 0.
  - 0xFF04–0xFF07 raise bit 9 (timer) with local address wr_addr[1:0].
  - 0xFF40–0xFF7F raise bit 10 (video registers) with local address wr_addr[5:0].
  - Every other address in the page, including 0xFF10–0xFF3F, raises no strobe.
- R8: At most one strobe bit is high in any cycle. No strobe is high in the cycle after one where wr_en is low.
- R9: Outputs follow the write presented at a rising edge and become visible just after that edge. tgt_data is the written byte whenever a strobe is high. tgt_addr is 0 whenever no strobe is high.
- R10: While rst_n is low, tgt_wstrb and tgt_addr are 0. Assertion of rst_n clears them without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request for this cycle |
| wr_addr | input | 16 | Processor write address |
| wr_data | input | DATA_W | Write data byte |
| xram_base | input | LOC_W | Current external memory bank offset |
| tgt_wstrb | output | 11 | One-hot target write strobes (bit order in R1–R7) |
| tgt_addr | output | LOC_W | Target-local address |
| tgt_data | output | DATA_W | Registered write data |

## Verification
Every routed result is due on the first rising edge after the write is presented. The bench drives each write on a falling edge and compares the outputs on the next falling edge. It also drives the following write at that same falling edge, which gives an exhaustive sweep of all 65536 addresses at one address per clock, with the bank offset varied per address. A second sweep with wr_en low checks that the strobes are quiet one edge later. Asynchronous reset is checked 1 ns after rst_n falls, between edges. After the reset release the bench waits for the two synchronizer edges before it sends any write.

// File: rtl/bwr_pkg.sv
package bwr_pkg;
  localparam int CPU_AW  = 16;
  localparam int NUM_TGT = 11;
  localparam int TGT_W   = 4;

  typedef enum logic [TGT_W-1:0] {
    TGT_BANKCTL = 4'd0,
    TGT_VRAM    = 4'd1,
    TGT_XRAM    = 4'd2,
    TGT_WRAM    = 4'd3,
    TGT_OAM     = 4'd4,
    TGT_HRAM    = 4'd5,
    TGT_IE      = 4'd6,
    TGT_IFLAG   = 4'd7,
    TGT_KEYPAD  = 4'd8,
    TGT_TIMER   = 4'd9,
    TGT_VIDREG  = 4'd10
  } tgt_e;
endpackage

// File: rtl/bwr_reset_sync.sv
module bwr_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/bwr_region_decode.sv
module bwr_region_decode
  import bwr_pkg::*;
(
  input  logic [CPU_AW-1:0] addr,
  output logic              hit,
  output tgt_e              tgt
);
  always_comb begin
    hit = 1'b1;
    tgt = TGT_BANKCTL;
    if (!addr[15]) begin
      tgt = TGT_BANKCTL;
    end else if (addr[14:13] != 2'b11) begin
      case (addr[14:13])
        2'b00:   tgt = TGT_VRAM;
        2'b01:   tgt = TGT_XRAM;
        default: tgt = TGT_WRAM;
      endcase
    end else if (addr[12:9] != 4'hF) begin
      // mirror window below the top two pages
      tgt = TGT_WRAM;
    end else if (!addr[8]) begin
      tgt = TGT_OAM;
      hit = (addr[7:0] < 8'hA0);
    end else if (&addr[7:0]) begin
      tgt = TGT_IE;
    end else if (addr[7]) begin
      tgt = TGT_HRAM;
    end else if (addr[6]) begin
      tgt = TGT_VIDREG;
    end else if (addr[5:4] != 2'b00) begin
      hit = 1'b0;
    end else begin
      case (addr[3:0])
        4'h0:                   tgt = TGT_KEYPAD;
        4'h4, 4'h5, 4'h6, 4'h7: tgt = TGT_TIMER;
        4'hF:                   tgt = TGT_IFLAG;
        default:                hit = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/bwr_local_addr.sv
module bwr_local_addr
  import bwr_pkg::*;
#(
  parameter int LOC_W = 16
) (
  input  tgt_e             tgt,
  input  logic [14:0]      addr_lo,
  input  logic [LOC_W-1:0] xram_base,
  output logic [LOC_W-1:0] loc_addr
);
  always_comb begin
    case (tgt)
      TGT_BANKCTL: loc_addr = LOC_W'(addr_lo[14:0]);
      TGT_VRAM,
      TGT_WRAM:    loc_addr = LOC_W'(addr_lo[12:0]);
      TGT_XRAM:    loc_addr = xram_base + LOC_W'(addr_lo[12:0]);
      TGT_OAM:     loc_addr = LOC_W'(addr_lo[7:0]);
      TGT_HRAM:    loc_addr = LOC_W'(addr_lo[6:0]);
      TGT_TIMER:   loc_addr = LOC_W'(addr_lo[1:0]);
      TGT_VIDREG:  loc_addr = LOC_W'(addr_lo[5:0]);
      default:     loc_addr = '0;
    endcase
  end
endmodule

// File: rtl/bwr_strobe_stage.sv
module bwr_strobe_stage
  import bwr_pkg::*;
#(
  parameter int LOC_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               hit,
  input  tgt_e               tgt,
  input  logic [LOC_W-1:0]   loc_addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [NUM_TGT-1:0] strb_q,
  output logic [LOC_W-1:0]   addr_q,
  output logic [DATA_W-1:0]  data_q
);
  logic               accept;
  logic [NUM_TGT-1:0] strb_d;
  logic [LOC_W-1:0]   addr_d;

  assign accept = wr_en & hit;

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_strb
    assign strb_d[g] = accept & (tgt == TGT_W'(g));
  end

  always_comb begin
    addr_d = accept ? loc_addr : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q <= '0;
      addr_q <= '0;
    end else begin
      strb_q <= strb_d;
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (accept) begin
      data_q <= wr_data;
    end
  end
endmodule

// File: rtl/bus_write_router.sv
module bus_write_router
  import bwr_pkg::*;
#(
  parameter int LOC_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [CPU_AW-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [LOC_W-1:0]   xram_base,
  output logic [NUM_TGT-1:0] tgt_wstrb,
  output logic [LOC_W-1:0]   tgt_addr,
  output logic [DATA_W-1:0]  tgt_data
);
  logic             rst_sync_n;
  logic             dec_hit;
  tgt_e             dec_tgt;
  logic [LOC_W-1:0] dec_loc;

  bwr_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bwr_region_decode u_dec (
    .addr (wr_addr),
    .hit  (dec_hit),
    .tgt  (dec_tgt)
  );

  bwr_local_addr #(.LOC_W(LOC_W)) u_loc (
    .tgt       (dec_tgt),
    .addr_lo   (wr_addr[14:0]),
    .xram_base (xram_base),
    .loc_addr  (dec_loc)
  );

  bwr_strobe_stage #(.LOC_W(LOC_W), .DATA_W(DATA_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .hit      (dec_hit),
    .tgt      (dec_tgt),
    .loc_addr (dec_loc),
    .wr_data  (wr_data),
    .strb_q   (tgt_wstrb),
    .addr_q   (tgt_addr),
    .data_q   (tgt_data)
  );
endmodule

// File: rtl/bus_write_router_chk.sv
module bus_write_router_chk
  import bwr_pkg::*;
#(
  parameter int LOC_W  = 16,
  parameter int DATA_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [CPU_AW-1:0]  wr_addr,
  input logic [DATA_W-1:0]  wr_data,
  input logic [LOC_W-1:0]   xram_base,
  input logic [NUM_TGT-1:0] tgt_wstrb,
  input logic [LOC_W-1:0]   tgt_addr,
  input logic [DATA_W-1:0]  tgt_data
);
  localparam logic [NUM_TGT-1:0] M_BANK = NUM_TGT'(1) << TGT_BANKCTL;
  localparam logic [NUM_TGT-1:0] M_VRAM = NUM_TGT'(1) << TGT_VRAM;
  localparam logic [NUM_TGT-1:0] M_XRAM = NUM_TGT'(1) << TGT_XRAM;
  localparam logic [NUM_TGT-1:0] M_WRAM = NUM_TGT'(1) << TGT_WRAM;
  localparam logic [NUM_TGT-1:0] M_IE   = NUM_TGT'(1) << TGT_IE;

  // R8
  onehot_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_wstrb));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> tgt_wstrb == '0);

  // R1
  bank_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr[15]) |=>
      (tgt_wstrb == M_BANK && tgt_addr == LOC_W'($past(wr_addr[14:0]))));

  // R2
  vram_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[15:13] == 3'b100) |=>
      (tgt_wstrb == M_VRAM && tgt_addr == LOC_W'($past(wr_addr[12:0]))));

  // R3
  xram_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[15:13] == 3'b101) |=>
      (tgt_wstrb == M_XRAM &&
       tgt_addr == $past(xram_base + LOC_W'(wr_addr[12:0]))));

  // R4
  wram_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= 16'hE000 && wr_addr < 16'hFE00) |=>
      (tgt_wstrb == M_WRAM && tgt_addr == LOC_W'($past(wr_addr[12:0]))));

  // R5
  oam_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[15:8] == 8'hFE && wr_addr[7:0] >= 8'hA0) |=>
      tgt_wstrb == '0);

  // R6
  ie_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 16'hFFFF) |=>
      (tgt_wstrb == M_IE && tgt_data == $past(wr_data)));

  // R7
  io_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= 16'hFF10 && wr_addr <= 16'hFF3F) |=>
      tgt_wstrb == '0);

  // R9
  addr_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_wstrb == '0) |-> (tgt_addr == '0));
endmodule

bind bus_write_router bus_write_router_chk #(.LOC_W(LOC_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .xram_base (xram_base),
  .tgt_wstrb (tgt_wstrb),
  .tgt_addr  (tgt_addr),
  .tgt_data  (tgt_data)
);

// File: tb/bus_write_router_bench.sv
`timescale 1ns/1ps
module bus_write_router_bench;
  localparam int LOC_W  = 16;
  localparam int DATA_W = 8;
  localparam int NT     = 11;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [15:0]       wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [LOC_W-1:0]  xram_base;
  logic [NT-1:0]     tgt_wstrb;
  logic [LOC_W-1:0]  tgt_addr;
  logic [DATA_W-1:0] tgt_data;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #4 clk = ~clk;

  bus_write_router #(.LOC_W(LOC_W), .DATA_W(DATA_W)) u_bus_write_router (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .xram_base (xram_base),
    .tgt_wstrb (tgt_wstrb),
    .tgt_addr  (tgt_addr),
    .tgt_data  (tgt_data)
  );

  // Expected routing computed from the address ranges of R1..R7.
  function automatic void model(input int a, input int base,
                                output int idx, output int loc, output string req);
    idx = -1; loc = 0;
    if (a <= 'h7FFF)                    begin idx = 0;  loc = a;            req = "R1"; end
    else if (a <= 'h9FFF)               begin idx = 1;  loc = a - 'h8000;   req = "R2"; end
    else if (a <= 'hBFFF)               begin idx = 2;  loc = (base + a - 'hA000) % 65536; req = "R3"; end
    else if (a <= 'hFDFF)               begin idx = 3;  loc = a % 8192;     req = "R4"; end
    else if (a <= 'hFE9F)               begin idx = 4;  loc = a - 'hFE00;   req = "R5"; end
    else if (a <= 'hFEFF)               begin                               req = "R5"; end
    else if (a == 'hFF00)               begin idx = 8;                      req = "R7"; end
    else if (a >= 'hFF04 && a <= 'hFF07) begin idx = 9; loc = a - 'hFF04;   req = "R7"; end
    else if (a == 'hFF0F)               begin idx = 7;                      req = "R7"; end
    else if (a >= 'hFF40 && a <= 'hFF7F) begin idx = 10; loc = a - 'hFF40;  req = "R7"; end
    else if (a >= 'hFF80 && a <= 'hFFFE) begin idx = 5; loc = a - 'hFF80;   req = "R6"; end
    else if (a == 'hFFFF)               begin idx = 6;                      req = "R6"; end
    else                                begin                               req = "R7"; end
  endfunction

  task automatic check_out(input string req, input logic [NT-1:0] es,
                           input logic [LOC_W-1:0] ea, input logic [DATA_W-1:0] ed,
                           input bit use_data);
    checks++;
    if (tgt_wstrb !== es || tgt_addr !== ea || (use_data && tgt_data !== ed)) begin
      errors++;
      $display("FAIL %s strb=%h addr=%h data=%h expected strb=%h addr=%h data=%h",
               req, tgt_wstrb, tgt_addr, tgt_data, es, ea, ed);
    end
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int    p_idx, p_loc;
    string p_req;
    logic [DATA_W-1:0] p_data;
    bit    pend;

    rst_n = 1'b0; wr_en = 1'b1; wr_addr = 16'h8000; wr_data = 8'h5A; xram_base = '0;
    repeat (3) @(negedge clk);
    // R10: held in reset despite an active write
    check_out("R10", '0, '0, '0, 1'b0);
    wr_en = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_out("R8", '0, '0, '0, 1'b0);

    // Exhaustive write sweep, one address per cycle (R1..R7, R9)
    pend = 1'b0;
    for (int a = 0; a < 65536; a++) begin
      @(negedge clk);
      if (pend)
        check_out(p_req, (p_idx >= 0) ? NT'(1) << p_idx : '0,
                  (p_idx >= 0) ? LOC_W'(p_loc) : '0, p_data, p_idx >= 0);
      wr_en     = 1'b1;
      wr_addr   = a[15:0];
      xram_base = LOC_W'((a * 40503 + 12345) & 'hFFFF);
      wr_data   = a[7:0] ^ a[15:8] ^ 8'h3C;
      model(a, int'(xram_base), p_idx, p_loc, p_req);
      p_data = wr_data;
      pend = 1'b1;
    end

    // Idle sweep: wr_en low must give no strobe one edge later (R8, R9)
    for (int a = 0; a < 65536; a += 7) begin
      @(negedge clk);
      if (pend)
        check_out(p_req, (p_idx >= 0) ? NT'(1) << p_idx : '0,
                  (p_idx >= 0) ? LOC_W'(p_loc) : '0, p_data, p_idx >= 0);
      wr_en   = 1'b0;
      wr_addr = a[15:0];
      wr_data = a[7:0];
      p_idx = -1; p_loc = 0; p_req = "R8";
      pend = 1'b1;
    end
    @(negedge clk);
    check_out("R8", '0, '0, '0, 1'b0);

    // R10: asynchronous clear between edges
    wr_en = 1'b1; wr_addr = 16'h9123; wr_data = 8'hA5;
    @(negedge clk);
    check_out("R2", NT'(1) << 1, LOC_W'(16'h1123), 8'hA5, 1'b1);
    @(posedge clk);
    #2 rst_n = 1'b0;
    #1 check_out("R10", '0, '0, '0, 1'b0);
    wr_en = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule